// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit operands over 32 clock cycles and returns a 64-bit product. A single 64-bit accumulator serves two purposes. Its lower half starts out holding the multiplier, and its upper half starts at zero. In each cycle the block looks at bit 0 of the accumulator. When that bit is set, a 32-bit adder adds the stored multiplicand into the upper half. In the same cycle the whole accumulator shifts right by one place. The adder's carry out moves into the top bit, so no product bit is lost. The multiplicand register is never shifted.

A caller presents both operands and pulses `start` while the block is idle. `busy` rises and stays high for the run. When the run ends, `done` pulses for one cycle and the result appears on `product`. When `signed_en` is high at start, both operands are taken as two's complement. The block multiplies their magnitudes and negates the result if the two signs differ.

Top module: `seq_mult`

## Requirements
- R1: While and directly after a synchronous reset, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled while idle raises `busy` at the next edge, and `busy` then stays high for exactly 32 cycles.
- R3: `done` is high for exactly one cycle, the first cycle in which `busy` is low again after a run.
- R4: With `signed_en` low, `product` equals the unsigned product of `a_in` and `b_in` as sampled at start. This includes operands whose partial sums carry out of 32 bits, for example all-ones times all-ones.
- R5: With `signed_en` high, `product` equals the 64-bit two's complement product of the operands, including cases where an operand is the most negative value.
- R6: A `start` that arrives while `busy` is high has no effect on the run in progress, on its result, or on the timing of `done`.
- R7: `product` changes only in the cycle in which `done` is high, and keeps its value at all other times.
- R8: Unsigned 17 times 19 gives 323 (binary 0101000011).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication when idle |
| signed_en | input | 1 | Treat the operands as two's complement, sampled at start |
| a_in | input | 32 | Multiplicand |
| b_in | input | 32 | Multiplier |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse when the result is written |
| product | output | 64 | Result of the most recent finished multiplication |

## Verification
The hardest condition to reach is a new `start` arriving in the middle of a run, paired with operands that differ from those of the run in progress. If the design acted on that start, the only visible sign would be a wrong product or a shifted `done`. The stimulus therefore fires a second start, with fresh operands, partway through a run. The behavioural model shows that the original result still comes out on time. Carries out of the 32-bit adder only occur when the upper half is already large, so all-ones operands and most-negative signed operands are applied to reach them.

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           signed_en,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W);

  logic [W-1:0]   mcand;
  logic [2*W-1:0] acc;
  logic [CW-1:0]  cnt;
  logic           flip;

  logic           a_neg, b_neg, last;
  logic [W-1:0]   a_mag, b_mag;
  logic [W:0]     sum;
  logic [2*W-1:0] acc_nx;

  assign a_neg  = signed_en & a_in[W-1];
  assign b_neg  = signed_en & b_in[W-1];
  assign a_mag  = a_neg ? (~a_in + 1'b1) : a_in;
  assign b_mag  = b_neg ? (~b_in + 1'b1) : b_in;
  assign sum    = {1'b0, acc[2*W-1:W]} + (acc[0] ? {1'b0, mcand} : {(W+1){1'b0}});
  assign acc_nx = {sum, acc[W-1:1]};
  assign last   = (cnt == CW'(W-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand   <= '0;
      acc     <= '0;
      cnt     <= '0;
      flip    <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      product <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        mcand <= a_mag;
        acc   <= {{W{1'b0}}, b_mag};
        flip  <= a_neg ^ b_neg;
        cnt   <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        acc <= acc_nx;
        cnt <= cnt + 1'b1;
        if (last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          product <= flip ? (~acc_nx + 1'b1) : acc_nx;
        end
      end
    end
  end

  p_run_length_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> busy);
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_edge_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_mcand_hold_r6: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mcand));
  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));
endmodule

// File: tb/sim_seq_mult.sv
module sim_seq_mult;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        signed_en = 1'b0;
  logic [31:0] a_in = '0, b_in = '0;
  logic        busy, done;
  logic [63:0] product;

  int tests = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  seq_mult u0 (.clk(clk), .rst(rst), .start(start), .signed_en(signed_en),
               .a_in(a_in), .b_in(b_in), .busy(busy), .done(done), .product(product));

  // behavioural reference
  logic        m_busy = 1'b0, m_done = 1'b0;
  logic [63:0] m_prod = '0, m_pend = '0;
  int          m_cnt = 0;
  bit          m_signed = 1'b0;

  function automatic logic [63:0] ref_mul(logic [31:0] a, logic [31:0] b, bit s);
    logic signed [63:0] sa, sb;
    if (s) begin
      sa = {{32{a[31]}}, a};
      sb = {{32{b[31]}}, b};
      return sa * sb;
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_prod <= '0; m_cnt <= 0;
    end else begin
      m_done <= 1'b0;
      if (start && !m_busy) begin
        m_busy   <= 1'b1;
        m_cnt    <= 0;
        m_pend   <= ref_mul(a_in, b_in, signed_en);
        m_signed <= signed_en;
      end else if (m_busy) begin
        m_cnt <= m_cnt + 1;
        if (m_cnt == 31) begin
          m_busy <= 1'b0; m_done <= 1'b1; m_prod <= m_pend;
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      tests++;
      if (busy !== m_busy) begin
        fails++; $display("FAIL R2 busy: actual %b expected %b", busy, m_busy);
      end
      tests++;
      if (done !== m_done) begin
        fails++; $display("FAIL R3 done: actual %b expected %b", done, m_done);
      end
      tests++;
      if (product !== m_prod) begin
        fails++;
        $display("FAIL %s/R7 product: actual %h expected %h",
                 m_signed ? "R5" : "R4", product, m_prod);
      end
    end
    if (cycles > 200000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++; $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(logic [31:0] a, logic [31:0] b, bit s, string req);
    @(negedge clk);
    a_in = a; b_in = b; signed_en = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0; a_in = ~a; b_in = b + 32'd7; signed_en = ~s;
    for (int i = 0; i < 32; i++) @(negedge clk);
    check({req, " done at end"}, {63'b0, done}, 64'd1);
    check(req, product, ref_mul(a, b, s));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", {63'b0, busy}, 64'd0);
    check("R1 done", {63'b0, done}, 64'd0);
    check("R1 product", product, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", product, 64'd0);

    run(32'd17, 32'd19, 1'b0, "R8");
    check("R8 value 323", product, 64'd323);
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R4 max");
    run(32'd0, 32'hDEAD_BEEF, 1'b0, "R4 zero");
    run(32'h8000_0001, 32'hF0F0_0F0F, 1'b0, "R4 carry");
    for (int k = 0; k < 6; k++) run($urandom, $urandom, 1'b0, "R4 rand");

    run(32'hFFFF_FFFD, 32'd5, 1'b1, "R5 neg*pos");
    run(32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1, "R5 neg*neg");
    run(32'h8000_0000, 32'h8000_0000, 1'b1, "R5 minneg sq");
    run(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R5 minneg*max");
    for (int k = 0; k < 6; k++) run($urandom, $urandom, 1'b1, "R5 rand");

    // R6: second start mid-run with other operands
    @(negedge clk);
    a_in = 32'd1234; b_in = 32'd5678; signed_en = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    a_in = 32'hFFFF_0000; b_in = 32'h0000_FFFF; signed_en = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 21; i++) @(negedge clk);
    check("R6 done timing", {63'b0, done}, 64'd1);
    check("R6 result kept", product, 64'd1234 * 64'd5678);

    // R7: result holds while idle
    repeat (5) @(negedge clk);
    check("R7 hold", product, 64'd1234 * 64'd5678);
    check("R2 idle", {63'b0, busy}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule